// File: doc/BRIEF.md
# Vectored Interrupt Acknowledge Controller

This block sits on the peripheral side of a small processor bus. It collects interrupt requests from several sources and pulls a shared active-low interrupt line low. When the processor fetches its interrupt vector, the block supplies that vector by pulling selected address lines low. The processor marks each bus cycle with a 2-bit status code and a clock phase. In the vector-fetch cycle the processor drives address lines A15..A2 high, and the block enables open-drain pull-downs on every line whose vector bit is zero. The processor then runs an acknowledge cycle, and the block retires the request it served.

The lowest-numbered pending source always wins. Each source has its own 14-bit vector input covering A15..A2, where bit k stands for line A(k+2). A vector of all ones leaves every line high and yields the default address 0xFFFC. A separate hold input models processor reset. While it is high, the interrupt line stays low and line A2 is pulled low, giving 0xFFF8. When the hold is released, the processor starts up.

The control is a four-state machine:
- IDLE: nothing is pending.
- WAIT: a request is pending and the interrupt line is low.
- VECT: a vector fetch has been seen and the winning source is locked.
- HOLD: reset hold.

Transitions:
- IDLE→WAIT when a request is latched.
- WAIT→VECT on a fetch cycle with clock phase low.
- VECT→WAIT on an acknowledge when other requests remain.
- VECT→IDLE on an acknowledge when nothing remains.
- Any state→HOLD while the hold input is high.
- HOLD→IDLE on release.

Top module: `irq_vector_ack`

## Requirements
- R1: After `rst_n` is deasserted and before any request arrives, `irq_n` is 1 and `pd_en` is all zero.
- R2: A request bit high for a single clock is latched. From the next cycle, `irq_n` is 0, and it stays 0 until that request is acknowledged.
- R3: Outside reset hold, `pd_en` is all zero unless the bus status is 2'b10 (fetch) and `phase` is 0. Bus status codes: 2'b11 acknowledge, 2'b10 instruction fetch, 2'b01 data, 2'b00 internal or wait.
- R4: During a fetch with `phase` 0 while a request is pending, `pd_en` equals the bitwise inverse of the winning source's 14-bit vector. A vector of all ones drives no line (0xFFFC).
- R5: Among pending sources, the lowest-numbered one is the winner.
- R6: An acknowledge (status 2'b11 with `phase` 0) in the VECT state clears only the served source. `irq_n` returns to 1 when nothing else is pending; otherwise the next pending source is vectored on the following fetch.
- R7: Once a fetch has selected a winner, later requests, including higher-priority ones, do not change the driven vector until the acknowledge.
- R8: A request arriving in the same cycle as an acknowledge stays pending.
- R9: While `rst_hold` is 1, the state is HOLD from the next cycle. In HOLD, `irq_n` is 0 and `pd_en` is 14'h0001 (A2 low, vector 0xFFF8) whatever the bus status is. Pending requests are discarded. After release, `irq_n` returns to 1.
- R10: An acknowledge that arrives before any vector fetch (state WAIT) is ignored: the request stays pending and is vectored on the next fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the controller |
| rst_hold | input | 1 | Processor reset hold request |
| req | input | NSRC | Interrupt request per source, latched when high |
| src_vec | input | NSRC*14 | Vector per source, A15..A2, source 0 in the low 14 bits |
| bus_st | input | 2 | Bus cycle status from the processor |
| phase | input | 1 | Processor clock phase, 0 = low half |
| irq_n | output | 1 | Active-low interrupt line |
| pd_en | output | 14 | Pull-down enables for A15..A2 (bit k = A(k+2)) |

## Verification
A wrong pending bit or a wrong state shows up at the ports within one cycle. It appears as `irq_n` at the wrong level, or as the wrong vector or a stray pull-down on the next fetch. The bench lines up fetch and acknowledge cycles against known vectors, so a wrong winner, a lost request or a missed clear changes the `pd_en` pattern at a known cycle. A faulty HOLD state is seen directly on A2, and a lingering pending bit shows as `irq_n` staying low after release.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_VECT = 2'd2,
        ST_HOLD = 2'd3
    } irqv_state_e;

    localparam logic [1:0] BS_INTERNAL = 2'b00;
    localparam logic [1:0] BS_DATA     = 2'b01;
    localparam logic [1:0] BS_FETCH    = 2'b10;
    localparam logic [1:0] BS_ACK      = 2'b11;
endpackage

// File: rtl/irqv_pend.sv
module irqv_pend #(
    parameter int NSRC = 4,
    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] clr_mask,
    input  logic            clr_all,
    output logic [NSRC-1:0] pend_q,
    output logic            any_next,
    output logic [IW-1:0]   win_idx
);
    logic [NSRC-1:0] pend_d;

    always_comb begin
        if (clr_all) pend_d = '0;
        else         pend_d = (pend_q & ~clr_mask) | req;
    end

    assign any_next = |pend_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    always_comb begin
        win_idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend_q[i]) win_idx = IW'(i);
        end
    end

    logic [NSRC-1:0] below_win;
    always_comb begin
        below_win = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (IW'(i) < win_idx) below_win[i] = 1'b1;
        end
    end

    AST_PRIO_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q != '0) |-> (pend_q[win_idx] && ((pend_q & below_win) == '0))); // R5
    AST_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_all |=> ((pend_q & $past(req)) == $past(req))); // R8
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_all && clr_mask != '0) |=> ((pend_q & $past(clr_mask & ~req)) == '0)); // R6
    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_mask)); // R6
endmodule

// File: rtl/irqv_fsm.sv
module irqv_fsm
    import irqv_pkg::*;
#(
    parameter int NSRC = 4,
    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    input  logic            any_next,
    input  logic [1:0]      bus_st,
    input  logic            phase,
    input  logic [IW-1:0]   win_idx,
    output irqv_state_e     state_q,
    output logic [IW-1:0]   sel,
    output logic [NSRC-1:0] clr_mask,
    output logic            irq_n,
    output logic            drive_en,
    output logic            hold_drv
);
    irqv_state_e state_d;
    logic [IW-1:0] win_q;
    logic fetch_lo;
    logic ack_lo;

    assign fetch_lo = (bus_st == BS_FETCH) && !phase;
    assign ack_lo   = (bus_st == BS_ACK) && !phase;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (hold)          state_d = ST_HOLD;
                else if (any_next) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (hold)          state_d = ST_HOLD;
                else if (fetch_lo) state_d = ST_VECT;
            end
            ST_VECT: begin
                if (hold)        state_d = ST_HOLD;
                else if (ack_lo) state_d = any_next ? ST_WAIT : ST_IDLE;
            end
            ST_HOLD: begin
                if (!hold) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            win_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_WAIT && fetch_lo) win_q <= win_idx;
        end
    end

    always_comb begin
        irq_n    = 1'b1;
        drive_en = 1'b0;
        hold_drv = 1'b0;
        sel      = win_idx;
        clr_mask = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WAIT: begin
                irq_n    = 1'b0;
                drive_en = fetch_lo;
            end
            ST_VECT: begin
                irq_n    = 1'b0;
                drive_en = fetch_lo;
                sel      = win_q;
                if (ack_lo) clr_mask[win_q] = 1'b1;
            end
            ST_HOLD: begin
                irq_n    = 1'b0;
                hold_drv = 1'b1;
            end
            default: ;
        endcase
    end

    AST_WIN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_VECT && $past(state_q) == ST_VECT) |-> $stable(win_q)); // R7
    AST_HOLD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !hold) |=> (state_q == ST_IDLE)); // R9
    AST_WAIT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !hold) |=> (state_q != ST_IDLE)); // R10
endmodule

// File: rtl/irqv_drive.sv
module irqv_drive #(
    parameter int NSRC = 4,
    parameter int AW   = 14,
    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC*AW-1:0] src_vec,
    input  logic [IW-1:0]      sel,
    input  logic               drive_en,
    input  logic               hold_drv,
    output logic [AW-1:0]      pd_en
);
    localparam logic [AW-1:0] HOLD_PD = AW'(1);

    logic [AW-1:0] vec_arr [NSRC];

    for (genvar g = 0; g < NSRC; g++) begin : g_unpack
        assign vec_arr[g] = src_vec[g*AW +: AW];
    end

    always_comb begin
        if (hold_drv)      pd_en = HOLD_PD;
        else if (drive_en) pd_en = ~vec_arr[sel];
        else               pd_en = '0;
    end
endmodule

// File: rtl/irq_vector_ack.sv
module irq_vector_ack
    import irqv_pkg::*;
#(
    parameter int NSRC = 4,
    parameter int AW   = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rst_hold,
    input  logic [NSRC-1:0]    req,
    input  logic [NSRC*AW-1:0] src_vec,
    input  logic [1:0]         bus_st,
    input  logic               phase,
    output logic               irq_n,
    output logic [AW-1:0]      pd_en
);
    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] clr_mask;
    logic            any_next;
    logic [IW-1:0]   win_idx;
    logic [IW-1:0]   sel;
    logic            drive_en;
    logic            hold_drv;
    irqv_state_e     state_q;

    irqv_pend #(.NSRC(NSRC)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .clr_mask (clr_mask),
        .clr_all  (rst_hold),
        .pend_q   (pend_q),
        .any_next (any_next),
        .win_idx  (win_idx)
    );

    irqv_fsm #(.NSRC(NSRC)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (rst_hold),
        .any_next (any_next),
        .bus_st   (bus_st),
        .phase    (phase),
        .win_idx  (win_idx),
        .state_q  (state_q),
        .sel      (sel),
        .clr_mask (clr_mask),
        .irq_n    (irq_n),
        .drive_en (drive_en),
        .hold_drv (hold_drv)
    );

    irqv_drive #(.NSRC(NSRC), .AW(AW)) u_drive (
        .src_vec  (src_vec),
        .sel      (sel),
        .drive_en (drive_en),
        .hold_drv (hold_drv),
        .pd_en    (pd_en)
    );

    AST_PD_ONLY_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_HOLD && !(bus_st == BS_FETCH && !phase)) |-> (pd_en == '0)); // R3
    AST_HOLD_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (pd_en == AW'(1) && !irq_n)); // R9
    AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q != '0) |-> !irq_n); // R2
endmodule

// File: tb/test_irq_vector_ack.sv
module test_irq_vector_ack;
    localparam int NSRC = 4;
    localparam int AW   = 14;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               rst_hold = 1'b0;
    logic [NSRC-1:0]    req = '0;
    logic [1:0]         bus_st = 2'b00;
    logic               phase = 1'b1;
    logic               irq_n;
    logic [AW-1:0]      pd_en;

    localparam logic [AW-1:0] V0 = 14'h3FFF;
    localparam logic [AW-1:0] V1 = 14'h3F00;
    localparam logic [AW-1:0] V2 = 14'h2AAA;
    localparam logic [AW-1:0] V3 = 14'h0123;
    logic [NSRC*AW-1:0] src_vec;
    assign src_vec = {V3, V2, V1, V0};

    always #10 clk = ~clk;

    irq_vector_ack #(.NSRC(NSRC), .AW(AW)) i_irq_vector_ack (
        .clk(clk), .rst_n(rst_n), .rst_hold(rst_hold), .req(req),
        .src_vec(src_vec), .bus_st(bus_st), .phase(phase),
        .irq_n(irq_n), .pd_en(pd_en)
    );

    typedef struct {
        logic          irq;
        logic [AW-1:0] pd;
        string         tag;
    } exp_t;

    exp_t sb[$];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic step(input logic [1:0] st, input logic ph, input logic [NSRC-1:0] rq,
                        input logic rh, input logic e_irq, input logic [AW-1:0] e_pd,
                        input string tag);
        exp_t e;
        @(negedge clk);
        #1;
        bus_st = st; phase = ph; req = rq; rst_hold = rh;
        e.irq = e_irq; e.pd = e_pd; e.tag = tag;
        sb.push_back(e);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #3;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_chk++;
                if (irq_n !== e.irq || pd_en !== e.pd) begin
                    n_bad++;
                    $display("FAIL %s: irq_n=%b pd_en=%h expected irq_n=%b pd_en=%h",
                             e.tag, irq_n, pd_en, e.irq, e.pd);
                end
            end
        end
    end

    initial begin : watchdog
        #(20 * 5000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        step(2'b00, 1, 4'b0000, 0, 1, 14'h0000, "R1 reset idle");
        // R2 single-cycle request from source 2
        step(2'b00, 1, 4'b0100, 0, 1, 14'h0000, "R2 before latch");
        step(2'b01, 0, 4'b0000, 0, 0, 14'h0000, "R2/R3 latched, data cycle quiet");
        step(2'b10, 1, 4'b0000, 0, 0, 14'h0000, "R3 fetch with phase high quiet");
        step(2'b10, 0, 4'b0000, 0, 0, ~V2,     "R4 vector of source 2");
        step(2'b10, 0, 4'b0000, 0, 0, ~V2,     "R4 vector held in VECT");
        step(2'b11, 1, 4'b0000, 0, 0, 14'h0000, "R6 ack phase high not taken");
        step(2'b11, 0, 4'b0000, 0, 0, 14'h0000, "R6 ack cycle");
        step(2'b00, 1, 4'b0000, 0, 1, 14'h0000, "R6 irq released");
        // R5 priority and R7 lock
        step(2'b00, 1, 4'b1010, 0, 1, 14'h0000, "R5 two requests");
        step(2'b10, 0, 4'b0000, 0, 0, ~V1,     "R5 lowest wins (src1)");
        step(2'b01, 1, 4'b0001, 0, 0, 14'h0000, "R7 higher request during VECT");
        step(2'b10, 0, 4'b0000, 0, 0, ~V1,     "R7 vector stays locked");
        step(2'b11, 0, 4'b0000, 0, 0, 14'h0000, "R6 ack src1");
        step(2'b10, 0, 4'b0000, 0, 0, ~V0,     "R6/R4 src0 next, default vector");
        // R8 request during ack
        step(2'b11, 0, 4'b0100, 0, 0, 14'h0000, "R8 ack src0 with new src2");
        step(2'b10, 0, 4'b0000, 0, 0, ~V2,     "R8 src2 kept pending");
        step(2'b11, 0, 4'b0000, 0, 0, 14'h0000, "R6 ack src2");
        step(2'b10, 0, 4'b0000, 0, 0, ~V3,     "R6 src3 still pending");
        step(2'b11, 0, 4'b0000, 0, 0, 14'h0000, "R6 ack src3");
        step(2'b00, 1, 4'b0000, 0, 1, 14'h0000, "R6 all served");
        // R10 ack before fetch ignored
        step(2'b00, 1, 4'b1000, 0, 1, 14'h0000, "R10 request src3");
        step(2'b11, 0, 4'b0000, 0, 0, 14'h0000, "R10 early ack");
        step(2'b10, 0, 4'b0000, 0, 0, ~V3,     "R10 still vectored");
        step(2'b11, 0, 4'b0000, 0, 0, 14'h0000, "R10 real ack");
        step(2'b00, 1, 4'b0000, 0, 1, 14'h0000, "R10 released");
        // R9 reset hold
        step(2'b00, 1, 4'b0010, 0, 1, 14'h0000, "R9 request before hold");
        step(2'b00, 1, 4'b0000, 1, 0, 14'h0000, "R9 hold asserted");
        step(2'b00, 1, 4'b0000, 1, 0, 14'h0001, "R9 HOLD drives A2 on idle bus");
        step(2'b10, 0, 4'b0000, 1, 0, 14'h0001, "R9 HOLD vector on fetch");
        step(2'b00, 1, 4'b0000, 0, 0, 14'h0001, "R9 release seen next edge");
        step(2'b00, 1, 4'b0000, 0, 1, 14'h0000, "R9 pending discarded");
        step(2'b10, 0, 4'b0000, 0, 1, 14'h0000, "R3/R9 fetch quiet after release");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule